// File: doc/BRIEF.md
# Hardware Flash Cycle Engine

This block runs flash operations on behalf of a host. The host does not pick SPI opcodes. It loads a 24-bit flash address, then writes one control word that holds an abstract cycle type, a byte count and a go bit. The engine then drives the whole exchange on a byte-level SPI master port. That exchange can include an automatic write-enable frame, the command frame with address and data, and a status-poll frame that waits for the flash to report not-busy. Payload bytes pass through a 64-byte buffer that the host reads and writes as little-endian 32-bit words.

Each cycle ends with one of three sticky flags: done, cycle error or access error. The host clears these flags by writing 1 to them, normally in the same write that sets go. A two-bit result field reports the flags in a fixed priority order. Write and erase cycles whose address falls inside a protected window are refused before any SPI activity. A cycle counter ends a cycle that never completes.

Top module: `flash_cycle_engine`

## Requirements
- R1: After reset the control word reads 0, the address word reads 0, `spi_cs_n` is 1 and `spi_req` is 0.
- R2: Control word fields are as follows. Bit 0 is go. Bits 3:1 hold the cycle type. Bits 9:4 hold the byte count minus one. Bit 16 is done, bit 17 is cycle error, bit 18 is access error and bit 19 is busy. Bits 21:20 hold the result. Host word 0 is the address and host word 1 is the control word. Host words 16 to 31 are the buffer, little-endian, with buffer byte 4w+k in bits 8k+7:8k of word 16+w.
- R3: A read cycle (type 0) is one frame. The frame holds opcode 0x03, then the address as three bytes with the most significant first, then count+1 received bytes stored from buffer byte 0. Done is set and no write-enable frame is sent.
- R4: A write cycle (type 1) sends three frames in order. The first is a frame holding only 0x06. The second holds 0x02, the three address bytes and count+1 bytes from buffer byte 0. The third starts with 0x05 and keeps reading status bytes until one has bit 0 clear. Done is set after that.
- R5: An erase cycle (type 2) sends the 0x06 frame, then a frame of 0x20 plus the three address bytes with no data, then the status-poll frame. Done is set after the poll.
- R6: Cycles without an address work as follows. Read ID (type 3, 0x9F) and read status (type 4, 0x05) send the opcode and then receive count+1 bytes into the buffer. Write status (type 5, 0x01) sends the 0x06 frame, then the opcode with count+1 buffer bytes, then the status poll.
- R7: Writing 1 to bits 16, 17 or 18 of the control word clears that flag. This also works in the same write that sets go, so the flags read 0 while the new cycle runs.
- R8: The result field is 3 when cycle error is set, otherwise 2 when access error is set, otherwise 1 when done is set, otherwise 0.
- R9: A write or erase cycle whose address is in the protected window [0x0F0000, 0x100000) sets access error, does not go busy and sends no frame.
- R10: If a cycle is still busy TIMEOUT_CYC cycles after go, the engine sets cycle error, raises `spi_cs_n` and returns to idle without setting done.
- R11: A control word write while busy leaves the running cycle unaffected, and its go bit, type and count are ignored.
- R12: Go with cycle type 6 or 7 sets cycle error and sends no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe |
| host_addr | input | HOST_AW | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| spi_cs_n | output | 1 | Flash chip select, low for the length of a frame |
| spi_req | output | 1 | Byte exchange request, held until acknowledged |
| spi_wdata | output | 8 | Byte to shift out |
| spi_ack | input | 1 | One-cycle pulse: the current byte exchange is complete |
| spi_rdata | input | 8 | Byte shifted in, valid with spi_ack |

## Verification
Reads of host words are combinational, so the bench samples them on the falling edge that follows setting the address. A control write becomes visible on the next falling edge, and the go-time clearing of flags and the busy flag are checked there. Refused cycles raise their error flag in that same cycle. A completed cycle drops busy on the edge after the last byte acknowledgement. The bench's flash model logs a frame one edge after `spi_cs_n` rises, so the bench polls busy and waits three more cycles before reading frame logs, buffer words and flags. The timeout case is also bounded in time: busy must fall between 290 and 310 cycles after the go write when TIMEOUT_CYC is 300.

// File: rtl/flash_cycle_engine.sv
module flash_cycle_engine #(
  parameter int BUF_BYTES = 64,
  parameter int HOST_AW = $clog2(BUF_BYTES / 4) + 1,
  parameter int TIMEOUT_CYC = 4096,
  parameter logic [23:0] PROT_LO = 24'h0F0000,
  parameter logic [23:0] PROT_HI = 24'h100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               spi_cs_n,
  output logic               spi_req,
  output logic [7:0]         spi_wdata,
  input  logic               spi_ack,
  input  logic [7:0]         spi_rdata
);
  localparam int CW  = $clog2(BUF_BYTES);
  localparam int TW  = $clog2(TIMEOUT_CYC + 1);
  localparam int WSW = HOST_AW - 1;
  localparam logic [2:0] T_READ = 3'd0, T_WRITE = 3'd1, T_ERASE = 3'd2,
                         T_RDID = 3'd3, T_RDSR = 3'd4, T_WRSR = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_GAP1, S_OP, S_ADR, S_DAT, S_GAP2, S_POP, S_PRD
  } state_t;

  function automatic logic needs_we(input logic [2:0] t);
    return t == T_WRITE || t == T_ERASE || t == T_WRSR;
  endfunction
  function automatic logic has_addr(input logic [2:0] t);
    return t == T_READ || t == T_WRITE || t == T_ERASE;
  endfunction
  function automatic logic is_rx(input logic [2:0] t);
    return t == T_READ || t == T_RDID || t == T_RDSR;
  endfunction
  function automatic logic [7:0] opcode(input logic [2:0] t);
    case (t)
      T_READ:  return 8'h03;
      T_WRITE: return 8'h02;
      T_ERASE: return 8'h20;
      T_RDID:  return 8'h9F;
      T_RDSR:  return 8'h05;
      default: return 8'h01;
    endcase
  endfunction

  state_t          state;
  logic [23:0]     faddr, lat_addr;
  logic [2:0]      cyc_type;
  logic [CW-1:0]   cnt, idx;
  logic            fl_done, fl_fcerr, fl_aerr;
  logic [TW-1:0]   tmo;
  logic [7:0]      mem [BUF_BYTES];

  wire           busy      = state != S_IDLE;
  wire           ctrl_wr   = host_we && host_addr == HOST_AW'(1);
  wire           buf_sel   = host_addr[HOST_AW-1];
  wire [WSW-1:0] wsel      = host_addr[WSW-1:0];
  wire [2:0]     new_type  = host_wdata[3:1];
  wire           in_prot   = faddr >= PROT_LO && faddr < PROT_HI;
  wire           tmo_hit   = busy && tmo == TW'(TIMEOUT_CYC - 1);
  wire           byte_st   = state inside {S_WREN, S_OP, S_ADR, S_DAT, S_POP, S_PRD};
  wire [1:0]     result    = fl_fcerr ? 2'd3 : fl_aerr ? 2'd2 : fl_done ? 2'd1 : 2'd0;
  wire           unused_hi = ^host_wdata[31:24];

  assign spi_req  = byte_st;
  assign spi_cs_n = !byte_st;

  always_comb begin
    case (state)
      S_WREN:  spi_wdata = 8'h06;
      S_OP:    spi_wdata = opcode(cyc_type);
      S_ADR:   spi_wdata = idx == CW'(0) ? lat_addr[23:16] :
                           idx == CW'(1) ? lat_addr[15:8] : lat_addr[7:0];
      S_DAT:   spi_wdata = is_rx(cyc_type) ? 8'h00 : mem[idx];
      S_POP:   spi_wdata = 8'h05;
      default: spi_wdata = 8'h00;
    endcase
  end

  always_comb begin
    host_rdata = '0;
    if (buf_sel)
      host_rdata = {mem[{wsel, 2'd3}], mem[{wsel, 2'd2}], mem[{wsel, 2'd1}], mem[{wsel, 2'd0}]};
    else if (host_addr == HOST_AW'(0))
      host_rdata[23:0] = faddr;
    else if (host_addr == HOST_AW'(1)) begin
      host_rdata[3:1]     = cyc_type;
      host_rdata[4 +: CW] = cnt;
      host_rdata[16]      = fl_done;
      host_rdata[17]      = fl_fcerr;
      host_rdata[18]      = fl_aerr;
      host_rdata[19]      = busy;
      host_rdata[21:20]   = result;
    end
  end

  always_ff @(posedge clk) begin
    if (host_we && buf_sel)
      for (int b = 0; b < 4; b++) mem[{wsel, 2'(b)}] <= host_wdata[8*b +: 8];
    if (state == S_DAT && spi_ack && is_rx(cyc_type) && !tmo_hit)
      mem[idx] <= spi_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      faddr    <= '0;
      lat_addr <= '0;
      cyc_type <= '0;
      cnt      <= '0;
      idx      <= '0;
      tmo      <= '0;
      fl_done  <= 1'b0;
      fl_fcerr <= 1'b0;
      fl_aerr  <= 1'b0;
    end else begin
      if (host_we && host_addr == HOST_AW'(0)) faddr <= host_wdata[23:0];
      if (ctrl_wr) begin
        if (host_wdata[16]) fl_done  <= 1'b0;
        if (host_wdata[17]) fl_fcerr <= 1'b0;
        if (host_wdata[18]) fl_aerr  <= 1'b0;
      end
      if (busy) tmo <= tmo + 1'b1;

      if (ctrl_wr && !busy) begin
        cyc_type <= new_type;
        cnt      <= host_wdata[4 +: CW];
        if (host_wdata[0]) begin
          if (new_type > T_WRSR)
            fl_fcerr <= 1'b1;
          else if (has_addr(new_type) && needs_we(new_type) && in_prot)
            fl_aerr <= 1'b1;
          else begin
            lat_addr <= faddr;
            tmo      <= '0;
            idx      <= '0;
            state    <= needs_we(new_type) ? S_WREN : S_OP;
          end
        end
      end else if (tmo_hit) begin
        state    <= S_IDLE;
        fl_fcerr <= 1'b1;
      end else begin
        case (state)
          S_WREN: if (spi_ack) state <= S_GAP1;
          S_GAP1: state <= S_OP;
          S_OP: if (spi_ack) begin
            idx   <= '0;
            state <= has_addr(cyc_type) ? S_ADR : S_DAT;
          end
          S_ADR: if (spi_ack) begin
            if (idx == CW'(2)) begin
              idx   <= '0;
              state <= cyc_type == T_ERASE ? S_GAP2 : S_DAT;
            end else idx <= idx + 1'b1;
          end
          S_DAT: if (spi_ack) begin
            if (idx == cnt) begin
              if (needs_we(cyc_type)) state <= S_GAP2;
              else begin
                state   <= S_IDLE;
                fl_done <= 1'b1;
              end
            end else idx <= idx + 1'b1;
          end
          S_GAP2: state <= S_POP;
          S_POP: if (spi_ack) state <= S_PRD;
          S_PRD: if (spi_ack && !spi_rdata[0]) begin
            state   <= S_IDLE;
            fl_done <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r9_quiet_refusal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_aerr) |-> spi_cs_n && $past(spi_cs_n));
  a_r10_tmo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tmo < TW'(TIMEOUT_CYC));
  a_r10_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_fcerr) |-> !busy && spi_cs_n);
  a_r11_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr && host_wdata[0]) |=> $stable(cyc_type) && $stable(cnt) && $stable(lat_addr));
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_done) |-> !busy && spi_cs_n && !$rose(fl_fcerr));
endmodule

// File: tb/tb_flash_cycle_engine.sv
`timescale 1ns/1ps
module tb_flash_cycle_engine;
  localparam int TMO = 300;
  logic clk = 0, rst_n = 0, host_we = 0;
  logic [4:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic spi_cs_n, spi_req, spi_ack = 0;
  logic [7:0] spi_wdata, spi_rdata = '0;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  flash_cycle_engine #(.TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_cs_n(spi_cs_n),
    .spi_req(spi_req), .spi_wdata(spi_wdata), .spi_ack(spi_ack), .spi_rdata(spi_rdata));

  // flash model
  logic [7:0] f_op = 0;
  logic [23:0] f_adr = 0;
  int f_idx = 0, dly = 0, frames = 0, busy_left = 0, busy_cfg = 3;
  logic in_fr = 0;
  logic [7:0] lg_op [32];
  int lg_len [32];
  logic [23:0] lg_adr [32];
  logic [7:0] pp [64];
  logic [7:0] wrsr_v = 0;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rsp(input int i);
    if (i == 0) return 8'hFF;
    if (f_op == 8'h03 && i >= 4) return pat(f_adr + 24'(i - 4));
    if (f_op == 8'h9F) return 8'(8'hC0 + i);
    if (f_op == 8'h05) return busy_left > 0 ? 8'h03 : 8'h02;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    spi_ack <= 1'b0;
    if (spi_cs_n) begin
      if (in_fr) begin
        lg_op[frames % 32]  <= f_op;
        lg_len[frames % 32] <= f_idx;
        lg_adr[frames % 32] <= f_adr;
        frames <= frames + 1;
        if (f_op == 8'h02 || f_op == 8'h20 || f_op == 8'h01) busy_left <= busy_cfg;
      end
      in_fr <= 0; f_idx <= 0; dly <= 0;
    end else begin
      in_fr <= 1;
      if (spi_req && !spi_ack) begin
        if (dly < 1) dly <= dly + 1;
        else begin
          dly <= 0;
          spi_ack <= 1'b1;
          spi_rdata <= rsp(f_idx);
          if (f_idx == 0) f_op <= spi_wdata;
          else if (f_idx <= 3) f_adr <= {f_adr[15:0], spi_wdata};
          if (f_op == 8'h02 && f_idx >= 4) pp[(f_idx - 4) % 64] <= spi_wdata;
          if (f_op == 8'h01 && f_idx == 1) wrsr_v <= spi_wdata;
          if (f_op == 8'h05 && f_idx >= 1 && busy_left > 0) busy_left <= busy_left - 1;
          f_idx <= f_idx + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic host_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic go(input logic [23:0] adr, input int typ, input int cnt, input bit clr);
    host_wr(5'd0, {8'h0, adr});
    host_wr(5'd1, (clr ? 32'h0007_0000 : 32'h0) | 32'(cnt << 4) | 32'(typ << 1) | 32'h1);
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] d;
    cyc = 0;
    do begin host_rd(5'd1, d); cyc++; end while (d[19] && cyc < 5000);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_frame(input string req, input int n, input logic [7:0] op, input int len);
    chk({req, " frame op"}, 32'(lg_op[n % 32]), 32'(op));
    chk({req, " frame length"}, 32'(lg_len[n % 32]), 32'(len));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    host_rd(5'd1, d); chk("R1 control after reset", d, 0);
    host_rd(5'd0, d); chk("R1 address after reset", d, 0);
    chk("R1 cs_n/req after reset", {30'h0, spi_cs_n, spi_req}, 32'h2);
  endtask

  task automatic t_buffer;
    logic [31:0] d;
    host_wr(5'd16, 32'hA1B2C3D4); host_wr(5'd31, 32'h01234567);
    host_rd(5'd16, d); chk("R2 buffer word 0", d, 32'hA1B2C3D4);
    host_rd(5'd31, d); chk("R2 buffer word 15", d, 32'h01234567);
  endtask

  task automatic t_read;
    logic [31:0] d; int c; int fb = frames;
    go(24'h012340, 0, 7, 1);
    wait_idle(c);
    chk("R3 frame count", 32'(frames - fb), 1);
    chk_frame("R3", fb, 8'h03, 12);
    chk("R3 address", 32'(lg_adr[fb % 32]), 32'h012340);
    host_rd(5'd16, d);
    chk("R3 buffer word 0", d, {pat(24'h43), pat(24'h42), pat(24'h41), pat(24'h40)});
    host_rd(5'd17, d);
    chk("R3 buffer word 1", d, {pat(24'h47), pat(24'h46), pat(24'h45), pat(24'h44)});
    host_rd(5'd1, d);
    chk("R2 R3 control fields", d & 32'h003F_03FE, 32'h0011_0070);
  endtask

  task automatic t_write;
    logic [31:0] d; int c; int fb;
    for (int w = 0; w < 4; w++) host_wr(5'(16 + w), 32'h10203040 + 32'(w * 32'h01010101));
    fb = frames;
    go(24'h000100, 1, 15, 1);
    host_rd(5'd1, d);
    chk("R7 flags cleared with go", d & 32'h000F_0000, 32'h0008_0000);
    wait_idle(c);
    chk("R4 frame count", 32'(frames - fb), 3);
    chk_frame("R4 wren", fb, 8'h06, 1);
    chk_frame("R4 program", fb + 1, 8'h02, 20);
    chk("R4 address", 32'(lg_adr[(fb + 1) % 32]), 32'h000100);
    chk_frame("R4 poll", fb + 2, 8'h05, 5);
    chk("R4 data byte 0", 32'(pp[0]), 32'h40);
    chk("R4 data byte 15", 32'(pp[15]), 32'h13);
    host_rd(5'd1, d); chk("R4 done", d & 32'h003F_0000, 32'h0011_0000);
  endtask

  task automatic t_erase;
    logic [31:0] d; int c; int fb = frames;
    go(24'h002000, 2, 0, 1);
    wait_idle(c);
    chk("R5 frame count", 32'(frames - fb), 3);
    chk_frame("R5 wren", fb, 8'h06, 1);
    chk_frame("R5 erase", fb + 1, 8'h20, 4);
    chk("R5 address", 32'(lg_adr[(fb + 1) % 32]), 32'h002000);
    chk_frame("R5 poll", fb + 2, 8'h05, 5);
    host_rd(5'd1, d); chk("R5 done", d & 32'h003F_0000, 32'h0011_0000);
  endtask

  task automatic t_noaddr;
    logic [31:0] d; int c; int fb = frames;
    go(24'h0, 3, 2, 1); wait_idle(c);
    chk_frame("R6 read id", fb, 8'h9F, 4);
    host_rd(5'd16, d); chk("R6 id bytes", d & 32'h00FF_FFFF, 32'h00C3C2C1);
    fb = frames;
    go(24'h0, 4, 0, 1); wait_idle(c);
    chk_frame("R6 read status", fb, 8'h05, 2);
    host_rd(5'd16, d); chk("R6 status byte", d & 32'hFF, 32'h02);
    host_wr(5'd16, 32'h0000_005C);
    fb = frames;
    go(24'h0, 5, 0, 1); wait_idle(c);
    chk("R6 write status frames", 32'(frames - fb), 3);
    chk_frame("R6 wren", fb, 8'h06, 1);
    chk_frame("R6 write status", fb + 1, 8'h01, 2);
    chk_frame("R6 poll", fb + 2, 8'h05, 5);
    chk("R6 status value", 32'(wrsr_v), 32'h5C);
  endtask

  task automatic t_prio;
    logic [31:0] d; int fb = frames;
    go(24'h0F8000, 1, 3, 0);
    host_rd(5'd1, d);
    chk("R9 access error, not busy", d & 32'h000F_0000, 32'h0005_0000);
    chk("R8 access error over done", 32'(d[21:20]), 2);
    go(24'h0F8000, 6, 0, 0);
    host_rd(5'd1, d);
    chk("R12 cycle error on bad type", 32'(d[17]), 1);
    chk("R8 cycle error first", 32'(d[21:20]), 3);
    repeat (4) @(negedge clk);
    chk("R9 R12 no frames", 32'(frames - fb), 0);
    host_wr(5'd1, 32'h0007_0000);
    host_rd(5'd1, d);
    chk("R7 write-1 clear", d & 32'h003F_0000, 0);
  endtask

  task automatic t_goignore;
    logic [31:0] d; int c; int fb = frames;
    go(24'h000200, 1, 3, 1);
    host_wr(5'd1, 32'h0000_0001);
    wait_idle(c);
    chk("R11 frame count", 32'(frames - fb), 3);
    chk_frame("R11 program", fb + 1, 8'h02, 8);
    host_rd(5'd1, d);
    chk("R11 type and count kept", d & 32'h3FE, 32'h032);
  endtask

  task automatic t_timeout;
    logic [31:0] d; int c;
    busy_cfg = 1000;
    go(24'h003000, 2, 0, 1);
    wait_idle(c);
    chk("R10 abort time in window", 32'(c >= 290 && c <= 310), 1);
    host_rd(5'd1, d);
    chk("R10 cycle error, no done", d & 32'h003F_0000, 32'h0032_0000);
    chk("R10 cs_n high", 32'(spi_cs_n), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_buffer;
    t_read;
    t_write;
    t_erase;
    t_noaddr;
    t_prio;
    t_goignore;
    t_timeout;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule